// File: doc/BRIEF.md
# Serial-load LCD column driver

This block is the segment (column) side of a dot-matrix LCD drive path. A display controller streams one row of pixel data into it serially, and the block holds that data in a shift store of two equal halves. The lower half is fed from one serial input and the upper half from a second one. Both halves advance on the same clock. Each half has its last stage brought out on a pin. This lets several drivers be cascaded, or lets the two halves be joined into one long chain by wiring the mid tap back to the upper input.

A load strobe copies the whole shift store into a parallel latch. The segment outputs are decoded only from that latch, so data that is still shifting never reaches the panel. For each segment, the latched bit and a frame-polarity input together select one of four drive levels, given as a 2-bit code. The polarity input is decoded combinationally, so a polarity flip at a frame boundary reaches every output in the same cycle. The block has no notion of duty ratio: it shifts and latches one row per load, whatever the number of common rows in a frame.

Top module: `lcd_col_driver`

## Requirements
- R1: On each rising `clk` edge without reset, both halves shift one stage toward the higher index. `serInLo` enters stage 0 and `serInHi` enters stage HALF_LEN.
- R2: `tapMid` shows stage HALF_LEN-1. A bit driven on `serInLo` before an edge appears on `tapMid` after exactly HALF_LEN edges.
- R3: `tapEnd` shows stage 2*HALF_LEN-1. A bit driven on `serInHi` before an edge appears on `tapEnd` after exactly HALF_LEN edges.
- R4: The halves are independent. The last stage of the lower half never enters the upper half.
- R5: On a rising edge with `loadStb` high and no reset, the latch takes the shift store contents as they were before that edge's shift.
- R6: On edges without a load, the latch and the segment outputs keep their values while data keeps shifting.
- R7: Level codes are: latched 1 with `altPol` high gives 2'b11, and with `altPol` low gives 2'b00. Latched 0 with `altPol` high gives 2'b10, and with `altPol` low gives 2'b01.
- R8: `altPol` acts combinationally. A change on it updates all segment codes with no clock edge.
- R9: Synchronous active-high `rst` clears the shift store and the latch, and takes priority over `loadStb`.
- R10: Latch bit i drives `segLevel[2*i+1:2*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and load clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| serInLo | input | 1 | Serial data into the lower half |
| serInHi | input | 1 | Serial data into the upper half |
| loadStb | input | 1 | Copy shift store to latch on this edge |
| altPol | input | 1 | Frame polarity select |
| tapMid | output | 1 | Last stage of the lower half |
| tapEnd | output | 1 | Last stage of the upper half |
| segLevel | output | 4*HALF_LEN | 2-bit drive level code per segment |

## Verification
The bench builds the block with HALF_LEN at its default of 20, which gives 40 segments and an 80-bit level bus. With this setting, a serial bit takes exactly 20 edges to reach each tap, so an off-by-one stage shows up as a wrong tap value one edge early or late. Every latched bit pattern is decoded under both polarities. This covers all four level codes on every segment position, as well as the reset-over-load priority.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

  localparam int NUM_HALVES = 2;

  typedef struct packed {
    logic clear;
    logic shift;
    logic load;
  } strobe_t;

  typedef enum logic [1:0] {
    LVL_RAIL      = 2'b00,
    LVL_BIAS_NEAR = 2'b01,
    LVL_BIAS_FAR  = 2'b10,
    LVL_DRIVE     = 2'b11
  } drive_lvl_t;

endpackage

// File: rtl/lcd_col_ctrl.sv
module lcd_col_ctrl
  import lcd_col_pkg::*;
(
  input  logic    rst,
  input  logic    loadStb,
  output strobe_t strb
);

  // Reset outranks load; shifting runs on every non-reset edge.
  always_comb begin
    strb.clear = rst;
    strb.shift = !rst;
    strb.load  = loadStb && !rst;
  end

endmodule

// File: rtl/lcd_col_chain.sv
module lcd_col_chain #(
  parameter int LEN = 20
) (
  input  logic           clk,
  input  logic           clearEn,
  input  logic           shiftEn,
  input  logic           serIn,
  output logic [LEN-1:0] stages
);

  logic [LEN-1:0] chainQ;

  always_ff @(posedge clk) begin
    if (clearEn) begin
      chainQ <= '0;
    end else if (shiftEn) begin
      chainQ <= {chainQ[LEN-2:0], serIn};
    end
  end

  assign stages = chainQ;

endmodule

// File: rtl/lcd_col_level.sv
module lcd_col_level
  import lcd_col_pkg::*;
(
  input  logic       bitIn,
  input  logic       altIn,
  output logic [1:0] level
);

  drive_lvl_t lvl;

  always_comb begin
    unique case ({bitIn, altIn})
      2'b11:   lvl = LVL_DRIVE;
      2'b10:   lvl = LVL_RAIL;
      2'b01:   lvl = LVL_BIAS_FAR;
      default: lvl = LVL_BIAS_NEAR;
    endcase
  end

  assign level = lvl;

  always_comb begin
    AST_LVL_POLARITY: assert (level[1] == altIn); // R7
  end

endmodule

// File: rtl/lcd_col_datapath.sv
module lcd_col_datapath
  import lcd_col_pkg::*;
#(
  parameter int HALF_LEN = 20,
  localparam int TOT = NUM_HALVES * HALF_LEN
) (
  input  logic             clk,
  input  strobe_t          strb,
  input  logic             serInLo,
  input  logic             serInHi,
  input  logic             altPol,
  output logic             tapMid,
  output logic             tapEnd,
  output logic [2*TOT-1:0] segLevel
);

  logic [NUM_HALVES-1:0] serVec;
  logic [TOT-1:0]        srQ;
  logic [TOT-1:0]        latchQ;

  assign serVec = {serInHi, serInLo};

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    lcd_col_chain #(.LEN(HALF_LEN)) u_chain (
      .clk    (clk),
      .clearEn(strb.clear),
      .shiftEn(strb.shift),
      .serIn  (serVec[h]),
      .stages (srQ[h*HALF_LEN +: HALF_LEN])
    );
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      latchQ <= '0;
    end else if (strb.load) begin
      latchQ <= srQ;
    end
  end

  assign tapMid = srQ[HALF_LEN-1];
  assign tapEnd = srQ[TOT-1];

  for (genvar i = 0; i < TOT; i++) begin : g_seg
    lcd_col_level u_lvl (
      .bitIn(latchQ[i]),
      .altIn(altPol),
      .level(segLevel[2*i +: 2])
    );
  end

  // Tracks that at least one clean edge followed a reset.
  logic seenRst;
  logic liveQ;
  always_ff @(posedge clk) begin
    if (strb.clear) seenRst <= 1'b1;
    liveQ <= seenRst && !strb.clear;
  end

  AST_TAP_MID_DELAY: assert property (@(posedge clk) disable iff (strb.clear)
    liveQ |-> tapMid == $past(srQ[HALF_LEN-2])); // R2

  AST_TAP_END_DELAY: assert property (@(posedge clk) disable iff (strb.clear)
    liveQ |-> tapEnd == $past(srQ[TOT-2])); // R3

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (strb.clear)
    (liveQ && strb.load) |=> latchQ == $past(srQ)); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (strb.clear)
    (liveQ && !strb.load) |=> $stable(latchQ)); // R6

endmodule

// File: rtl/lcd_col_driver.sv
module lcd_col_driver
  import lcd_col_pkg::*;
#(
  parameter int HALF_LEN = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  serInLo,
  input  logic                  serInHi,
  input  logic                  loadStb,
  input  logic                  altPol,
  output logic                  tapMid,
  output logic                  tapEnd,
  output logic [4*HALF_LEN-1:0] segLevel
);

  strobe_t strb;

  lcd_col_ctrl u_ctrl (
    .rst    (rst),
    .loadStb(loadStb),
    .strb   (strb)
  );

  lcd_col_datapath #(.HALF_LEN(HALF_LEN)) u_dp (
    .clk     (clk),
    .strb    (strb),
    .serInLo (serInLo),
    .serInHi (serInHi),
    .altPol  (altPol),
    .tapMid  (tapMid),
    .tapEnd  (tapEnd),
    .segLevel(segLevel)
  );

endmodule

// File: tb/sim_lcd_col_driver.sv
module sim_lcd_col_driver;

  localparam int CLK_P = 10;
  localparam int HALF  = 20;
  localparam int TOT   = 2 * HALF;
  localparam int NPAT  = 6;
  localparam logic [TOT-1:0] PATS [NPAT] = '{
    40'hFF_FFFF_FFFF, 40'h00_0000_0000, 40'hAA_AAAA_AAAA,
    40'h3C_5A69_E187, 40'h80_0001_0000, 40'hD2_7B04_9C3F
  };

  logic clk = 1'b0;
  logic rst, serInLo, serInHi, loadStb, altPol;
  logic tapMid, tapEnd;
  logic [2*TOT-1:0] segLevel;

  logic [TOT-1:0] srM, latM;
  int total = 0;
  int bad   = 0;

  lcd_col_driver #(.HALF_LEN(HALF)) u0 (
    .clk(clk), .rst(rst), .serInLo(serInLo), .serInHi(serInHi),
    .loadStb(loadStb), .altPol(altPol), .tapMid(tapMid), .tapEnd(tapEnd),
    .segLevel(segLevel)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [2*TOT-1:0] expSeg(logic [TOT-1:0] l, logic a);
    logic [2*TOT-1:0] r;
    for (int i = 0; i < TOT; i++)
      r[2*i +: 2] = l[i] ? (a ? 2'b11 : 2'b00) : (a ? 2'b10 : 2'b01);
    return r;
  endfunction

  task automatic chk(string req, logic [2*TOT-1:0] act, logic [2*TOT-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One clock: inputs applied now (after a falling edge), model updated at
  // the rising edge, outputs compared at the following falling edge.
  task automatic cyc(logic lo, logic hi, logic ld, logic al, logic rs);
    serInLo = lo; serInHi = hi; loadStb = ld; altPol = al; rst = rs;
    @(posedge clk);
    if (rs) begin
      srM = '0; latM = '0;
    end else begin
      if (ld) latM = srM;
      srM[HALF-1:0]   = {srM[HALF-2:0], lo};
      srM[TOT-1:HALF] = {srM[TOT-2:HALF], hi};
    end
    @(negedge clk);
    chk("R2 tapMid", tapMid, srM[HALF-1]);
    chk("R3/R4 tapEnd", tapEnd, srM[TOT-1]);
    chk("R6 seg from latch", segLevel, expSeg(latM, al));
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    srM = '0; latM = '0;
    rst = 1'b1; serInLo = 0; serInHi = 0; loadStb = 0; altPol = 0;
    @(negedge clk);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    // R9 reset state: taps low, all segments at 01 with polarity low
    chk("R9 reset tapMid", tapMid, 0);
    chk("R9 reset tapEnd", tapEnd, 0);
    chk("R9 reset seg", segLevel, {TOT{2'b01}});

    // Vector table walk: shift each pattern in, load, decode both polarities
    for (int p = 0; p < NPAT; p++) begin
      for (int k = 0; k < HALF; k++)
        cyc(PATS[p][HALF-1-k], PATS[p][TOT-1-k], 0, p[0], 0);
      cyc(0, 0, 1, 0, 0);
      // R5 latch holds exactly the pattern (contents before the load edge)
      chk("R5 R10 latch alt0", segLevel, expSeg(PATS[p], 1'b0));
      // R8 polarity change without a clock edge
      altPol = 1'b1; #1;
      chk("R7 R8 alt1", segLevel, expSeg(PATS[p], 1'b1));
      altPol = 1'b0; #1;
      chk("R7 R8 alt back 0", segLevel, expSeg(PATS[p], 1'b0));
      // R6 keep shifting without load: outputs unchanged
      for (int k = 0; k < 5; k++) cyc(~k[0], k[0], 0, 0, 0);
      chk("R6 hold", segLevel, expSeg(PATS[p], 1'b0));
    end

    // R7 R10 single bit: latch bit 3 only
    cyc(0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R10 bit3 code11", segLevel, {{(TOT-4){2'b10}}, 2'b11, {3{2'b10}}});

    // R1 R2 exact delay: single 1 on lower input reaches tapMid on edge HALF
    cyc(0, 0, 0, 0, 1);
    cyc(1, 0, 0, 0, 0);
    for (int k = 1; k < HALF - 1; k++) cyc(0, 0, 0, 0, 0);
    chk("R2 not early", tapMid, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R1 R2 mid at HALF", tapMid, 1);

    // R3 same for upper input
    cyc(0, 0, 0, 0, 1);
    cyc(0, 1, 0, 0, 0);
    for (int k = 1; k < HALF - 1; k++) cyc(0, 0, 0, 0, 0);
    chk("R3 not early", tapEnd, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R3 end at HALF", tapEnd, 1);

    // R4 lower half full of ones does not leak into upper half
    cyc(0, 0, 0, 0, 1);
    for (int k = 0; k < 2 * HALF; k++) cyc(1, 0, 0, 0, 0);
    chk("R4 mid high", tapMid, 1);
    chk("R4 end stays low", tapEnd, 0);

    // R9 reset beats load
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, 1, 0, 1);
    chk("R9 reset over load", segLevel, {TOT{2'b01}});
    chk("R9 reset clears chain", {tapEnd, tapMid}, 2'b00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule